// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Update

This block is the arithmetic and logic stage of an 8-bit accumulator processor. It is purely combinational. Each cycle the caller presents an operation code, the register operand (accumulator, or X/Y for compares), a memory operand and the current 8-bit status byte. The block returns the result byte, a new status byte and a write mask that tells the caller which status bits this operation defines.

Two-operand operations (logic, add, subtract, compare, bit test) combine the register operand with the memory operand. Single-operand operations (shifts, rotates, increment, decrement, pass-through) act on the memory operand only. For the accumulator forms of those, the caller routes the accumulator into the memory operand port. Compare and bit test leave the register operand unchanged on the result port. Arithmetic is always binary.

The status byte uses fixed bit positions, because the caller's branch logic decodes them: N is bit 7, V bit 6, bit 5 is always 1, B bit 4, D bit 3, I bit 2, Z bit 1, C bit 0.

Top module: `accu_alu`

## Requirements
- R1: Codes 0 (OR), 1 (AND) and 2 (XOR) return the named bitwise combination of reg_a and mem_b. N is set to result bit 7, Z is set when the result is zero, and flag_wr is 0x82.
- R2: Code 3 (add with carry) returns (reg_a + mem_b + C) mod 256. C is set when the full sum exceeds 0xFF. V is set when both operands have the same sign and the result's sign differs from it. N and Z follow the result, and flag_wr is 0xC3.
- R3: Code 4 (subtract with borrow) returns (reg_a − mem_b − (1 − C)) mod 256. C is set when the exact difference is not negative. V is set when the result's sign differs from reg_a's and mem_b's sign also differs from reg_a's. N and Z follow the result, and flag_wr is 0xC3.
- R4: Code 5 (compare) sets C when reg_a ≥ mem_b as unsigned numbers, and takes N and Z from the 8-bit value reg_a − mem_b. res_out equals reg_a, and flag_wr is 0x83.
- R5: Code 6 (shift left) returns mem_b shifted left by one with bit 0 cleared, and C takes mem_b bit 7. Code 7 (shift right) returns mem_b shifted right by one with bit 7 cleared, and C takes mem_b bit 0. N and Z follow the result, and flag_wr is 0x83.
- R6: Code 8 (rotate left) puts the incoming C into bit 0, and code 9 (rotate right) puts it into bit 7. In both, the bit shifted out becomes C, N and Z follow the result, and flag_wr is 0x83.
- R7: Code 10 returns mem_b + 1 and code 11 returns mem_b − 1, both wrapping modulo 256. N and Z follow the result, and flag_wr is 0x82.
- R8: Code 12 (bit test) copies mem_b bit 7 into N and bit 6 into V, and sets Z when (reg_a AND mem_b) is zero. res_out equals reg_a, and flag_wr is 0xC2.
- R9: Code 13 (pass-through for loads and transfers) returns mem_b. N and Z follow it, and flag_wr is 0x82.
- R10: Codes 14 and 15 are reserved. They return reg_a with flag_wr = 0x00 and leave every status bit except bit 5 unchanged.
- R11: Every status bit not set in flag_wr (I, D, B, and any of N/V/Z/C the operation does not define) passes from stat_in to stat_out unchanged. stat_out bit 5 is always 1.
- R12: The D bit (stat_in bit 3) has no effect on any result or flag. Add and subtract give the binary result whether D is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encodings in R1–R10 requirements) |
| reg_a | input | DW | Register operand (accumulator, X or Y) |
| mem_b | input | DW | Memory operand, or the accumulator for single-operand forms |
| stat_in | input | 8 | Current status byte |
| res_out | output | DW | Result byte |
| stat_out | output | 8 | Updated status byte |
| flag_wr | output | 8 | Mask of status bits defined by this operation |

## Verification
The bench builds the block at its default 8-bit data width. At that width, every operation code can be swept against all 256 register values and a spread of memory values: all multiples of 0x11 plus 0x01, 0x7F and 0x80. Each combination is run with carry both clear and set, and with a varying pattern in the other status bits. This reaches every carry-out, signed-overflow, zero and wrap boundary of the add, subtract, compare, increment and decrement paths. A separate pass repeats add and subtract with D forced on and then off, which shows that decimal mode has no influence.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

    localparam int OPW = 4;
    localparam int SW  = 8;

    localparam int FC_POS = 0;
    localparam int FZ_POS = 1;
    localparam int FI_POS = 2;
    localparam int FD_POS = 3;
    localparam int FB_POS = 4;
    localparam int F1_POS = 5;
    localparam int FV_POS = 6;
    localparam int FN_POS = 7;

    localparam logic [SW-1:0] MSK_C   = SW'(1) << FC_POS;
    localparam logic [SW-1:0] MSK_Z   = SW'(1) << FZ_POS;
    localparam logic [SW-1:0] MSK_V   = SW'(1) << FV_POS;
    localparam logic [SW-1:0] MSK_N   = SW'(1) << FN_POS;
    localparam logic [SW-1:0] MSK_ONE = SW'(1) << F1_POS;

    localparam logic [SW-1:0] WR_NZ    = MSK_N | MSK_Z;
    localparam logic [SW-1:0] WR_NZC   = MSK_N | MSK_Z | MSK_C;
    localparam logic [SW-1:0] WR_NVZC  = MSK_N | MSK_V | MSK_Z | MSK_C;
    localparam logic [SW-1:0] WR_NVZ   = MSK_N | MSK_V | MSK_Z;

    typedef enum logic [OPW-1:0] {
        OP_OR   = 4'd0,
        OP_AND  = 4'd1,
        OP_XOR  = 4'd2,
        OP_ADC  = 4'd3,
        OP_SBC  = 4'd4,
        OP_CMP  = 4'd5,
        OP_ASL  = 4'd6,
        OP_LSR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_BIT  = 4'd12,
        OP_PASS = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } nvzc_t;

endpackage

// File: rtl/accu_alu_logic.sv
module accu_alu_logic #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] or_o,
    output logic [DW-1:0] and_o,
    output logic [DW-1:0] xor_o,
    output logic          bt_zero_o,
    output logic          bt_top_o,
    output logic          bt_next_o
);
    localparam int MSB = DW - 1;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign or_o[i]  = a_i[i] | b_i[i];
        assign and_o[i] = a_i[i] & b_i[i];
        assign xor_o[i] = a_i[i] ^ b_i[i];
    end

    assign bt_zero_o = ~|and_o;
    assign bt_top_o  = b_i[MSB];
    assign bt_next_o = b_i[MSB-1];
endmodule

// File: rtl/accu_alu_arith.sv
module accu_alu_arith #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] add_o,
    output logic          add_c_o,
    output logic          add_v_o,
    output logic [DW-1:0] sub_o,
    output logic          sub_c_o,
    output logic          sub_v_o,
    output logic [DW-1:0] cmp_o,
    output logic          cmp_c_o,
    output logic [DW-1:0] inc_o,
    output logic [DW-1:0] dec_o
);
    localparam int MSB = DW - 1;

    logic [DW:0] add_full;
    logic [DW:0] sub_full;
    logic [DW:0] cmp_full;

    // Subtraction as addition of the inverted operand: carry out = no borrow.
    assign add_full = {1'b0, a_i} + {1'b0, b_i}  + {{DW{1'b0}}, cin_i};
    assign sub_full = {1'b0, a_i} + {1'b0, ~b_i} + {{DW{1'b0}}, cin_i};
    assign cmp_full = {1'b0, a_i} + {1'b0, ~b_i} + {{DW{1'b0}}, 1'b1};

    assign add_o   = add_full[MSB:0];
    assign add_c_o = add_full[DW];
    assign add_v_o = (a_i[MSB] == b_i[MSB]) && (add_o[MSB] != a_i[MSB]);

    assign sub_o   = sub_full[MSB:0];
    assign sub_c_o = sub_full[DW];
    assign sub_v_o = (sub_o[MSB] != a_i[MSB]) && (b_i[MSB] != a_i[MSB]);

    assign cmp_o   = cmp_full[MSB:0];
    assign cmp_c_o = cmp_full[DW];

    assign inc_o = b_i + DW'(1);
    assign dec_o = b_i - DW'(1);
endmodule

// File: rtl/accu_alu_shift.sv
module accu_alu_shift #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] asl_o,
    output logic [DW-1:0] lsr_o,
    output logic [DW-1:0] rol_o,
    output logic [DW-1:0] ror_o,
    output logic          hi_out_o,
    output logic          lo_out_o
);
    localparam int MSB = DW - 1;

    for (genvar i = 1; i < DW; i++) begin : g_left
        assign asl_o[i] = b_i[i-1];
        assign rol_o[i] = b_i[i-1];
    end
    for (genvar i = 0; i < MSB; i++) begin : g_right
        assign lsr_o[i] = b_i[i+1];
        assign ror_o[i] = b_i[i+1];
    end

    assign asl_o[0]   = 1'b0;
    assign rol_o[0]   = cin_i;
    assign lsr_o[MSB] = 1'b0;
    assign ror_o[MSB] = cin_i;

    assign hi_out_o = b_i[MSB];
    assign lo_out_o = b_i[0];
endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  reg_a,
    input  logic [DW-1:0]  mem_b,
    input  logic [SW-1:0]  stat_in,
    output logic [DW-1:0]  res_out,
    output logic [SW-1:0]  stat_out,
    output logic [SW-1:0]  flag_wr
);
    localparam int MSB = DW - 1;

    alu_op_e op;
    logic    cin;

    logic [DW-1:0] y_or, y_and, y_xor;
    logic          bt_zero, bt_top, bt_next;
    logic [DW-1:0] y_add, y_sub, y_cmp, y_inc, y_dec;
    logic          add_c, add_v, sub_c, sub_v, cmp_c;
    logic [DW-1:0] y_asl, y_lsr, y_rol, y_ror;
    logic          hi_out, lo_out;

    logic [DW-1:0] res_q;
    logic [DW-1:0] nz_src;
    nvzc_t         fl;
    logic [SW-1:0] wr;
    logic [SW-1:0] fl_vec;

    assign op  = alu_op_e'(op_sel);
    assign cin = stat_in[FC_POS];

    accu_alu_logic #(.DW(DW)) u_logic (
        .a_i       (reg_a),
        .b_i       (mem_b),
        .or_o      (y_or),
        .and_o     (y_and),
        .xor_o     (y_xor),
        .bt_zero_o (bt_zero),
        .bt_top_o  (bt_top),
        .bt_next_o (bt_next)
    );

    accu_alu_arith #(.DW(DW)) u_arith (
        .a_i     (reg_a),
        .b_i     (mem_b),
        .cin_i   (cin),
        .add_o   (y_add),
        .add_c_o (add_c),
        .add_v_o (add_v),
        .sub_o   (y_sub),
        .sub_c_o (sub_c),
        .sub_v_o (sub_v),
        .cmp_o   (y_cmp),
        .cmp_c_o (cmp_c),
        .inc_o   (y_inc),
        .dec_o   (y_dec)
    );

    accu_alu_shift #(.DW(DW)) u_shift (
        .b_i      (mem_b),
        .cin_i    (cin),
        .asl_o    (y_asl),
        .lsr_o    (y_lsr),
        .rol_o    (y_rol),
        .ror_o    (y_ror),
        .hi_out_o (hi_out),
        .lo_out_o (lo_out)
    );

    always_comb begin
        res_q  = reg_a;
        nz_src = reg_a;
        fl     = '0;
        wr     = '0;
        unique case (op)
            OP_OR:   begin res_q = y_or;  nz_src = y_or;  wr = WR_NZ; end
            OP_AND:  begin res_q = y_and; nz_src = y_and; wr = WR_NZ; end
            OP_XOR:  begin res_q = y_xor; nz_src = y_xor; wr = WR_NZ; end
            OP_ADC:  begin
                res_q = y_add; nz_src = y_add;
                fl.c  = add_c; fl.v = add_v; wr = WR_NVZC;
            end
            OP_SBC:  begin
                res_q = y_sub; nz_src = y_sub;
                fl.c  = sub_c; fl.v = sub_v; wr = WR_NVZC;
            end
            OP_CMP:  begin
                res_q = reg_a; nz_src = y_cmp;
                fl.c  = cmp_c; wr = WR_NZC;
            end
            OP_ASL:  begin res_q = y_asl; nz_src = y_asl; fl.c = hi_out; wr = WR_NZC; end
            OP_LSR:  begin res_q = y_lsr; nz_src = y_lsr; fl.c = lo_out; wr = WR_NZC; end
            OP_ROL:  begin res_q = y_rol; nz_src = y_rol; fl.c = hi_out; wr = WR_NZC; end
            OP_ROR:  begin res_q = y_ror; nz_src = y_ror; fl.c = lo_out; wr = WR_NZC; end
            OP_INC:  begin res_q = y_inc; nz_src = y_inc; wr = WR_NZ; end
            OP_DEC:  begin res_q = y_dec; nz_src = y_dec; wr = WR_NZ; end
            OP_BIT:  begin res_q = reg_a; wr = WR_NVZ; end
            OP_PASS: begin res_q = mem_b; nz_src = mem_b; wr = WR_NZ; end
            OP_RSV0, OP_RSV1: begin res_q = reg_a; wr = '0; end
            default: begin res_q = reg_a; wr = '0; end
        endcase

        if (op == OP_BIT) begin
            fl.n = bt_top;
            fl.v = bt_next;
            fl.z = bt_zero;
        end else begin
            fl.n = nz_src[MSB];
            fl.z = ~|nz_src;
        end
    end

    always_comb begin
        fl_vec         = '0;
        fl_vec[FN_POS] = fl.n;
        fl_vec[FV_POS] = fl.v;
        fl_vec[FZ_POS] = fl.z;
        fl_vec[FC_POS] = fl.c;
    end

    assign res_out  = res_q;
    assign flag_wr  = wr;
    assign stat_out = (stat_in & ~wr) | (fl_vec & wr) | MSK_ONE;
endmodule

// File: rtl/accu_alu_chk.sv
module accu_alu_chk
    import accu_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  reg_a,
    input logic [DW-1:0]  mem_b,
    input logic [SW-1:0]  stat_in,
    input logic [DW-1:0]  res_out,
    input logic [SW-1:0]  stat_out,
    input logic [SW-1:0]  flag_wr
);
    logic nz_op;
    assign nz_op = (op_sel != 4'd5) && (op_sel != 4'd12) && (op_sel < 4'd14);

    always_comb begin
        AST_KEEP_UNMASKED: assert (((stat_out ^ stat_in) & ~flag_wr & ~MSK_ONE) == '0); // R11
        AST_BIT5_HIGH: assert (stat_out[F1_POS]); // R11
        AST_CMP_HOLDS_REG: assert (!(op_sel == 4'd5) || (res_out == reg_a)); // R4
        AST_BIT_COPIES: assert (!(op_sel == 4'd12) ||
            ((stat_out[FN_POS] == mem_b[DW-1]) && (stat_out[FV_POS] == mem_b[DW-2]))); // R8
        AST_RESERVED_IDLE: assert (!(op_sel >= 4'd14) || ((flag_wr == '0) && (res_out == reg_a))); // R10
        AST_NZ_FROM_RESULT: assert (!nz_op ||
            ((stat_out[FN_POS] == res_out[DW-1]) && (stat_out[FZ_POS] == (res_out == '0)))); // R1
        AST_ASL_CARRY: assert (!(op_sel == 4'd6) || (stat_out[FC_POS] == mem_b[DW-1])); // R5
    end
endmodule

bind accu_alu accu_alu_chk #(.DW(DW)) u_accu_alu_chk (
    .op_sel   (op_sel),
    .reg_a    (reg_a),
    .mem_b    (mem_b),
    .stat_in  (stat_in),
    .res_out  (res_out),
    .stat_out (stat_out),
    .flag_wr  (flag_wr)
);

// File: tb/accu_alu_bench.sv
`timescale 1ns/1ps
module accu_alu_bench;

    logic       clk = 1'b0;
    logic [3:0] op_sel;
    logic [7:0] reg_a, mem_b, stat_in;
    logic [7:0] res_out, stat_out, flag_wr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    accu_alu #(.DW(8)) u_accu_alu (
        .op_sel   (op_sel),
        .reg_a    (reg_a),
        .mem_b    (mem_b),
        .stat_in  (stat_in),
        .res_out  (res_out),
        .stat_out (stat_out),
        .flag_wr  (flag_wr)
    );

    function automatic string req_of(input int op);
        case (op)
            0, 1, 2:  return "R1";
            3:        return "R2";
            4:        return "R3";
            5:        return "R4";
            6, 7:     return "R5";
            8, 9:     return "R6";
            10, 11:   return "R7";
            12:       return "R8";
            13:       return "R9";
            default:  return "R10";
        endcase
    endfunction

    // Arithmetic reference model built from the requirements.
    task automatic model(input int op, input int a, input int b, input int st,
                         output int r, output int so, output int m);
        int c, n, v, z, cy, nzv, full;
        c = st & 1; v = 0; cy = 0; r = a; nzv = a; m = 0;
        case (op)
            0: begin r = a | b; nzv = r; m = 'h82; end
            1: begin r = a & b; nzv = r; m = 'h82; end
            2: begin r = a ^ b; nzv = r; m = 'h82; end
            3: begin
                full = a + b + c; r = full % 256; nzv = r; m = 'hC3;
                cy = (full > 255) ? 1 : 0;
                v = (((a ^ b) & 'h80) == 0 && ((r ^ a) & 'h80) != 0) ? 1 : 0;
            end
            4: begin
                full = a - b - (1 - c); r = (full + 512) % 256; nzv = r; m = 'hC3;
                cy = (full >= 0) ? 1 : 0;
                v = (((r ^ a) & 'h80) != 0 && ((b ^ a) & 'h80) != 0) ? 1 : 0;
            end
            5: begin r = a; nzv = (a - b + 256) % 256; cy = (a >= b) ? 1 : 0; m = 'h83; end
            6: begin r = (b * 2) % 256; nzv = r; cy = b / 128; m = 'h83; end
            7: begin r = b / 2; nzv = r; cy = b % 2; m = 'h83; end
            8: begin r = (b * 2) % 256 + c; nzv = r; cy = b / 128; m = 'h83; end
            9: begin r = b / 2 + c * 128; nzv = r; cy = b % 2; m = 'h83; end
            10: begin r = (b + 1) % 256; nzv = r; m = 'h82; end
            11: begin r = (b + 255) % 256; nzv = r; m = 'h82; end
            12: begin r = a; m = 'hC2; end
            13: begin r = b; nzv = r; m = 'h82; end
            default: begin r = a; m = 0; end
        endcase
        if (op == 12) begin
            n = (b / 128) % 2; v = (b / 64) % 2; z = ((a & b) == 0) ? 1 : 0;
        end else begin
            n = nzv / 128; z = (nzv == 0) ? 1 : 0;
        end
        so = ((st & ~m) & 'hFF) | (((n * 128) + (v * 64) + (z * 2) + cy) & m) | 'h20;
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h (op=%0d a=%02h b=%02h st=%02h)",
                     tag, what, act, exp, op_sel, reg_a, mem_b, stat_in);
        end
    endtask

    task automatic apply_and_check(input int op, input int a, input int b, input int st,
                                   input string tag_override);
        int r, so, m;
        string t;
        op_sel = 4'(op); reg_a = 8'(a); mem_b = 8'(b); stat_in = 8'(st);
        #2;
        model(op, a, b, st, r, so, m);
        t = (tag_override.len() != 0) ? tag_override : req_of(op);
        check(t, "result", int'(res_out), r);
        check(t, "mask", int'(flag_wr), m);
        check(t, "flags", int'(stat_out) & m, so & m);
        check("R11", "unmasked", int'(stat_out) & ~m & 'hFF, so & ~m & 'hFF);
        #2;
    endtask

    int blist [19] = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88,
                       8'h99, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF, 8'h01, 8'h7F, 8'h80};

    initial begin
        // Idle state: all inputs zero, OR code, expect Z set and bit 5 high (R1, R11)
        apply_and_check(0, 0, 0, 0, "R1");
        check("R11", "idle status", int'(stat_out), 'h22);

        // Main sweep: every code, every register value, spread of memory values,
        // carry both ways, other status bits patterned (D toggles too, R12).
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 19; bi++) begin
                    for (int c = 0; c < 2; c++) begin
                        int st;
                        st = (((a * 7) + (bi * 13) + op) & 'hFE) | c;
                        apply_and_check(op, a, blist[bi], st, "");
                    end
                end
            end
        end

        // R12: add and subtract with D forced on and off must give binary results.
        for (int op = 3; op < 5; op++) begin
            for (int a = 0; a < 256; a += 5) begin
                for (int bi = 0; bi < 19; bi++) begin
                    apply_and_check(op, a, blist[bi], 'h08, "R12");
                    apply_and_check(op, a, blist[bi], 'h09, "R12");
                    apply_and_check(op, a, blist[bi], 'hF6, "R12");
                end
            end
        end

        // Boundary cases named explicitly.
        apply_and_check(3, 'h7F, 'h01, 'h00, "R2");  // signed overflow into 0x80
        apply_and_check(3, 'hFF, 'h00, 'h01, "R2");  // carry out with zero result
        apply_and_check(4, 'h00, 'h00, 'h00, "R3");  // borrow in wraps to 0xFF
        apply_and_check(4, 'h80, 'h01, 'h01, "R3");  // signed overflow to 0x7F
        apply_and_check(5, 'h40, 'h40, 'h00, "R4");  // equal compare
        apply_and_check(8, 'h00, 'h80, 'h01, "R6");  // rotate carries in and out
        apply_and_check(9, 'h00, 'h01, 'h00, "R6");  // rotate to zero
        apply_and_check(11, 'h00, 'h00, 'h00, "R7"); // decrement wraps
        apply_and_check(12, 'h0F, 'hC0, 'h00, "R8"); // bit test, disjoint bits
        apply_and_check(15, 'h5A, 'hFF, 'hDF, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule